// File: doc/BRIEF.md
# Banked Pending Interrupt Priority Resolver

This block looks at a table of interrupt vectors and names the single pending interrupt that should be taken next. Every vector number has two copies, one in the secure bank and one in the non-secure bank. Each copy carries its own enable bit, pending bit and 8-bit raw priority. A per-vector flag marks vectors whose priority is fixed and negative. These vectors always outrank any programmable level.

Each security state has its own binary point. The binary point says how many low bits of a raw priority are subpriority; the remaining high bits are the group priority. A secure-bank copy is always judged with the secure binary point. A non-secure-bank copy is judged with the binary point of the security state that its routing flag names.

All candidates are compared in a single combinational tree. The result is captured in output registers, so the outputs reflect the inputs one clock later. The outputs are the winning vector, its group priority, its subpriority, and whether the winner came from the secure bank.

Top module: `prio_resolver`

## Requirements
- R1: A bank copy takes part only when both its enable bit and its pending bit are set. Any other copy has no effect on the outputs.
- R2: Among taking part copies, the one with the numerically lowest group priority wins.
- R3: When group priorities are equal and not negative, the lower subpriority wins.
- R4: When group priority and subpriority are both equal, the lower vector number wins.
- R5: For a full tie within one vector number, the secure-bank copy wins and `win_sec` is 1.
- R6: With binary point b, clamped to 8, the subpriority is the raw value with all but its low b bits cleared, and the group priority is the raw value with those low b bits cleared. A secure-bank copy uses `sec_bpoint`. A non-secure-bank copy uses `sec_bpoint` when its `ns_tgt_sec` bit is 1 and `ns_bpoint` when it is 0.
- R7: A copy whose vector has its `fixed_neg` bit set has group priority −(1 + raw[1:0]), a value from −1 to −4. Its subpriority is reported as 0, and ties between such copies never look at subpriority.
- R8: Vector 0 is never reported, whatever its inputs.
- R9: When no copy takes part, `win_valid` is 0, `win_vec` is 0, `win_grp` is the sentinel 256, `win_sub` is 0 and `win_sec` is 0.
- R10: The outputs are registered. After a rising edge they show the result for the inputs present at that edge. While `rst` is high at an edge, they take the R9 idle values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| s_en | input | NUM_VEC | Secure-bank enable bits, bit i for vector i |
| s_pend | input | NUM_VEC | Secure-bank pending bits |
| s_prio | input | NUM_VEC*PRIO_W | Secure-bank raw priorities, vector i at bits [i*PRIO_W +: PRIO_W] |
| n_en | input | NUM_VEC | Non-secure-bank enable bits |
| n_pend | input | NUM_VEC | Non-secure-bank pending bits |
| n_prio | input | NUM_VEC*PRIO_W | Non-secure-bank raw priorities |
| ns_tgt_sec | input | NUM_VEC | Non-secure-bank copy is judged with the secure binary point |
| fixed_neg | input | NUM_VEC | Vector has a fixed negative priority |
| sec_bpoint | input | BP_W | Number of subpriority bits for the secure state |
| ns_bpoint | input | BP_W | Number of subpriority bits for the non-secure state |
| win_valid | output | 1 | A winner exists |
| win_vec | output | VEC_W | Winning vector number |
| win_grp | output | PRIO_W+2 | Winner's group priority, two's complement |
| win_sub | output | PRIO_W | Winner's subpriority |
| win_sec | output | 1 | Winner came from the secure bank |

## Verification
The bench targets the tie-break ladder. It uses pairs that differ only in subpriority, only in vector number, or only in bank. A design that took the later candidate on a tie, or that skipped the subpriority step, would then report the wrong vector or the wrong bank. Non-secure copies are routed to the secure binary point while the two binary points differ. A resolver that picked the mask from the bank instead of from the route would split group from subpriority in the wrong place. Fixed negative vectors carry different low raw bits, so any subpriority comparison among them would show. An enabled, pending vector 0 and disabled-but-pending copies must leave the idle outputs untouched.

// File: rtl/prio_res_pkg.sv
package prio_res_pkg;
  localparam int KEY_W = 16;

  // Strict precedence: a beats b. Subpriority counts only for non-negative groups.
  function automatic logic beats(input logic signed [KEY_W-1:0] ga,
                                 input logic [KEY_W-1:0] sa,
                                 input logic signed [KEY_W-1:0] gb,
                                 input logic [KEY_W-1:0] sb);
    logic r;
    r = 1'b0;
    if (ga < gb) r = 1'b1;
    else if (ga == gb && ga >= 0 && sa < sb) r = 1'b1;
    return r;
  endfunction
endpackage

// File: rtl/bp_mask.sv
module bp_mask #(
  parameter int PRIO_W = 8,
  parameter int BP_W   = 4
) (
  input  logic [BP_W-1:0]   bpoint,
  output logic [PRIO_W-1:0] grp_mask
);
  logic [BP_W-1:0] nsub;

  always_comb begin
    nsub = (32'(bpoint) > PRIO_W) ? BP_W'(PRIO_W) : bpoint;
    grp_mask = {PRIO_W{1'b1}} << nsub;
  end
endmodule

// File: rtl/cand_eval.sv
module cand_eval #(
  parameter int PRIO_W = 8,
  parameter int VEC_W  = 4,
  parameter int GRP_W  = 10,
  parameter int IDX    = 1,
  parameter bit SEC    = 1'b1
) (
  input  logic                    en,
  input  logic                    pend,
  input  logic [PRIO_W-1:0]       raw,
  input  logic                    fixed,
  input  logic                    tgt_sec,
  input  logic [PRIO_W-1:0]       s_mask,
  input  logic [PRIO_W-1:0]       n_mask,
  output logic                    c_valid,
  output logic signed [GRP_W-1:0] c_grp,
  output logic [PRIO_W-1:0]       c_sub,
  output logic [VEC_W-1:0]        c_vec,
  output logic                    c_sec
);
  logic [PRIO_W-1:0] mask;

  always_comb begin
    mask    = (SEC || tgt_sec) ? s_mask : n_mask;
    c_valid = en & pend;
    c_vec   = VEC_W'(IDX);
    c_sec   = SEC;
    if (fixed) begin
      c_grp = -($signed(GRP_W'(raw[1:0])) + $signed(GRP_W'(1)));
      c_sub = '0;
    end else begin
      c_grp = $signed(GRP_W'(raw & mask));
      c_sub = raw & ~mask;
    end
  end
endmodule

// File: rtl/pick_tree.sv
module pick_tree
  import prio_res_pkg::*;
#(
  parameter int N_LEAF = 32,
  parameter int PRIO_W = 8,
  parameter int VEC_W  = 4,
  parameter int GRP_W  = 10
) (
  input  logic                    l_valid [N_LEAF],
  input  logic signed [GRP_W-1:0] l_grp   [N_LEAF],
  input  logic [PRIO_W-1:0]       l_sub   [N_LEAF],
  input  logic [VEC_W-1:0]        l_vec   [N_LEAF],
  input  logic                    l_sec   [N_LEAF],
  output logic                    t_valid,
  output logic signed [GRP_W-1:0] t_grp,
  output logic [PRIO_W-1:0]       t_sub,
  output logic [VEC_W-1:0]        t_vec,
  output logic                    t_sec
);
  localparam int N_NODE = 2 * N_LEAF;

  logic                    nv [N_NODE];
  logic signed [GRP_W-1:0] ng [N_NODE];
  logic [PRIO_W-1:0]       ns [N_NODE];
  logic [VEC_W-1:0]        nx [N_NODE];
  logic                    nb [N_NODE];

  assign nv[0] = 1'b0;
  assign ng[0] = '0;
  assign ns[0] = '0;
  assign nx[0] = '0;
  assign nb[0] = 1'b0;

  for (genvar k = 0; k < N_LEAF; k++) begin : g_leaf
    assign nv[N_LEAF+k] = l_valid[k];
    assign ng[N_LEAF+k] = l_grp[k];
    assign ns[N_LEAF+k] = l_sub[k];
    assign nx[N_LEAF+k] = l_vec[k];
    assign nb[N_LEAF+k] = l_sec[k];
  end

  // Heap-ordered nodes: the left child is earlier in scan order and keeps ties.
  for (genvar n = 1; n < N_LEAF; n++) begin : g_node
    logic take_r;
    always_comb begin
      if (!nv[2*n+1])      take_r = 1'b0;
      else if (!nv[2*n])   take_r = 1'b1;
      else                 take_r = beats(KEY_W'(ng[2*n+1]), KEY_W'(ns[2*n+1]),
                                          KEY_W'(ng[2*n]),   KEY_W'(ns[2*n]));
    end
    assign nv[n] = nv[2*n] | nv[2*n+1];
    assign ng[n] = take_r ? ng[2*n+1] : ng[2*n];
    assign ns[n] = take_r ? ns[2*n+1] : ns[2*n];
    assign nx[n] = take_r ? nx[2*n+1] : nx[2*n];
    assign nb[n] = take_r ? nb[2*n+1] : nb[2*n];
  end

  assign t_valid = nv[1];
  assign t_grp   = ng[1];
  assign t_sub   = ns[1];
  assign t_vec   = nx[1];
  assign t_sec   = nb[1];
endmodule

// File: rtl/prio_resolver.sv
module prio_resolver #(
  parameter int NUM_VEC = 16,
  parameter int PRIO_W  = 8,
  parameter int BP_W    = $clog2(PRIO_W + 1),
  parameter int VEC_W   = $clog2(NUM_VEC),
  parameter int GRP_W   = PRIO_W + 2
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic [NUM_VEC-1:0]          s_en,
  input  logic [NUM_VEC-1:0]          s_pend,
  input  logic [NUM_VEC*PRIO_W-1:0]   s_prio,
  input  logic [NUM_VEC-1:0]          n_en,
  input  logic [NUM_VEC-1:0]          n_pend,
  input  logic [NUM_VEC*PRIO_W-1:0]   n_prio,
  input  logic [NUM_VEC-1:0]          ns_tgt_sec,
  input  logic [NUM_VEC-1:0]          fixed_neg,
  input  logic [BP_W-1:0]             sec_bpoint,
  input  logic [BP_W-1:0]             ns_bpoint,
  output logic                        win_valid,
  output logic [VEC_W-1:0]            win_vec,
  output logic signed [GRP_W-1:0]     win_grp,
  output logic [PRIO_W-1:0]           win_sub,
  output logic                        win_sec
);
  localparam int N_CAND = 2 * NUM_VEC;
  localparam int N_LEAF = 2 ** $clog2(N_CAND);
  localparam logic signed [GRP_W-1:0] NOEXC = GRP_W'(2 ** PRIO_W);

  logic [PRIO_W-1:0] s_mask, n_mask;

  bp_mask #(.PRIO_W(PRIO_W), .BP_W(BP_W)) u_smask (.bpoint(sec_bpoint), .grp_mask(s_mask));
  bp_mask #(.PRIO_W(PRIO_W), .BP_W(BP_W)) u_nmask (.bpoint(ns_bpoint),  .grp_mask(n_mask));

  logic                    l_valid [N_LEAF];
  logic signed [GRP_W-1:0] l_grp   [N_LEAF];
  logic [PRIO_W-1:0]       l_sub   [N_LEAF];
  logic [VEC_W-1:0]        l_vec   [N_LEAF];
  logic                    l_sec   [N_LEAF];

  // Leaf 2i is the secure copy of vector i, leaf 2i+1 the non-secure copy.
  for (genvar i = 0; i < NUM_VEC; i++) begin : g_vec
    for (genvar b = 0; b < 2; b++) begin : g_bank
      localparam int  LK  = 2 * i + b;
      localparam bit  SEC = (b == 0);
      if (i == 0) begin : g_skip
        assign l_valid[LK] = 1'b0;
        assign l_grp[LK]   = '0;
        assign l_sub[LK]   = '0;
        assign l_vec[LK]   = '0;
        assign l_sec[LK]   = 1'b0;
      end else begin : g_ev
        cand_eval #(
          .PRIO_W(PRIO_W), .VEC_W(VEC_W), .GRP_W(GRP_W), .IDX(i), .SEC(SEC)
        ) u_ev (
          .en      (SEC ? s_en[i]   : n_en[i]),
          .pend    (SEC ? s_pend[i] : n_pend[i]),
          .raw     (SEC ? s_prio[i*PRIO_W +: PRIO_W] : n_prio[i*PRIO_W +: PRIO_W]),
          .fixed   (fixed_neg[i]),
          .tgt_sec (ns_tgt_sec[i]),
          .s_mask  (s_mask),
          .n_mask  (n_mask),
          .c_valid (l_valid[LK]),
          .c_grp   (l_grp[LK]),
          .c_sub   (l_sub[LK]),
          .c_vec   (l_vec[LK]),
          .c_sec   (l_sec[LK])
        );
      end
    end
  end

  for (genvar k = N_CAND; k < N_LEAF; k++) begin : g_pad
    assign l_valid[k] = 1'b0;
    assign l_grp[k]   = '0;
    assign l_sub[k]   = '0;
    assign l_vec[k]   = '0;
    assign l_sec[k]   = 1'b0;
  end

  logic                    t_valid, t_sec;
  logic signed [GRP_W-1:0] t_grp;
  logic [PRIO_W-1:0]       t_sub;
  logic [VEC_W-1:0]        t_vec;

  pick_tree #(
    .N_LEAF(N_LEAF), .PRIO_W(PRIO_W), .VEC_W(VEC_W), .GRP_W(GRP_W)
  ) u_tree (
    .l_valid(l_valid), .l_grp(l_grp), .l_sub(l_sub), .l_vec(l_vec), .l_sec(l_sec),
    .t_valid(t_valid), .t_grp(t_grp), .t_sub(t_sub), .t_vec(t_vec), .t_sec(t_sec)
  );

  always_ff @(posedge clk) begin
    if (rst || !t_valid) begin
      win_valid <= 1'b0;
      win_vec   <= '0;
      win_grp   <= NOEXC;
      win_sub   <= '0;
      win_sec   <= 1'b0;
    end else begin
      win_valid <= 1'b1;
      win_vec   <= t_vec;
      win_grp   <= t_grp;
      win_sub   <= t_sub;
      win_sec   <= t_sec;
    end
  end
endmodule

// File: rtl/prio_resolver_chk.sv
module prio_resolver_chk #(
  parameter int NUM_VEC = 16,
  parameter int PRIO_W  = 8,
  parameter int VEC_W   = 4,
  parameter int GRP_W   = 10
) (
  input logic                    clk,
  input logic                    rst,
  input logic [NUM_VEC-1:0]      s_en,
  input logic [NUM_VEC-1:0]      s_pend,
  input logic [NUM_VEC-1:0]      n_en,
  input logic [NUM_VEC-1:0]      n_pend,
  input logic                    win_valid,
  input logic [VEC_W-1:0]        win_vec,
  input logic signed [GRP_W-1:0] win_grp,
  input logic [PRIO_W-1:0]       win_sub,
  input logic                    win_sec
);
  localparam logic signed [GRP_W-1:0] NOEXC = GRP_W'(2 ** PRIO_W);

  logic [NUM_VEC-1:0] live_s_q, live_n_q;
  always_ff @(posedge clk) begin
    live_s_q <= s_en & s_pend;
    live_n_q <= n_en & n_pend;
  end

  a_r1_winner_live: assert property (@(posedge clk) disable iff (rst)
    win_valid |-> (win_sec ? live_s_q[win_vec] : live_n_q[win_vec]));

  a_r8_no_vec0: assert property (@(posedge clk) disable iff (rst)
    win_valid |-> win_vec != '0);

  a_r9_idle_vals: assert property (@(posedge clk) disable iff (rst)
    !win_valid |-> (win_vec == '0 && win_grp == NOEXC && win_sub == '0 && !win_sec));

  a_r9_sentinel_idle_only: assert property (@(posedge clk) disable iff (rst)
    win_valid |-> win_grp < NOEXC);

  a_r7_fixed_no_sub: assert property (@(posedge clk) disable iff (rst)
    (win_valid && win_grp < 0) |-> (win_sub == '0 && win_grp >= -4));

  a_r10_reset_idle: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> !win_valid);
endmodule

bind prio_resolver prio_resolver_chk #(
  .NUM_VEC(NUM_VEC), .PRIO_W(PRIO_W), .VEC_W(VEC_W), .GRP_W(GRP_W)
) u_chk (
  .clk(clk), .rst(rst), .s_en(s_en), .s_pend(s_pend), .n_en(n_en), .n_pend(n_pend),
  .win_valid(win_valid), .win_vec(win_vec), .win_grp(win_grp),
  .win_sub(win_sub), .win_sec(win_sec)
);

// File: tb/tb_prio_resolver.sv
`timescale 1ns/1ps
module tb_prio_resolver;
  localparam int NV = 16;
  localparam int PW = 8;
  localparam int BW = $clog2(PW + 1);
  localparam int VW = $clog2(NV);
  localparam int GW = PW + 2;
  localparam int SENT = 2 ** PW;

  logic clk = 1'b0;
  logic rst;
  logic [NV-1:0] s_en, s_pend, n_en, n_pend, ns_tgt_sec, fixed_neg;
  logic [NV*PW-1:0] s_prio, n_prio;
  logic [BW-1:0] sec_bpoint, ns_bpoint;
  logic win_valid, win_sec;
  logic [VW-1:0] win_vec;
  logic signed [GW-1:0] win_grp;
  logic [PW-1:0] win_sub;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  prio_resolver #(.NUM_VEC(NV), .PRIO_W(PW)) dut (
    .clk(clk), .rst(rst), .s_en(s_en), .s_pend(s_pend), .s_prio(s_prio),
    .n_en(n_en), .n_pend(n_pend), .n_prio(n_prio), .ns_tgt_sec(ns_tgt_sec),
    .fixed_neg(fixed_neg), .sec_bpoint(sec_bpoint), .ns_bpoint(ns_bpoint),
    .win_valid(win_valid), .win_vec(win_vec), .win_grp(win_grp),
    .win_sub(win_sub), .win_sec(win_sec)
  );

  // Behavioural reference: walk vectors upward, secure copy first, replace only when strictly better.
  task automatic model(output bit v, output int vec, output int g, output int sb, output bit sec);
    v = 0; vec = 0; g = SENT; sb = 0; sec = 0;
    if (rst) return;
    for (int i = 1; i < NV; i++) begin
      for (int b = 1; b >= 0; b--) begin
        bit live; int raw; int bp; int gg; int ss;
        live = (b == 1) ? (s_en[i] && s_pend[i]) : (n_en[i] && n_pend[i]);
        raw  = (b == 1) ? int'(s_prio[i*PW +: PW]) : int'(n_prio[i*PW +: PW]);
        if (!live) continue;
        if (fixed_neg[i]) begin
          gg = -(1 + (raw % 4));
          ss = 0;
        end else begin
          bp = (b == 1 || ns_tgt_sec[i]) ? int'(sec_bpoint) : int'(ns_bpoint);
          if (bp > PW) bp = PW;
          ss = raw % (1 << bp);
          gg = raw - ss;
        end
        if (gg < g || (gg == g && gg >= 0 && ss < sb)) begin
          v = 1; vec = i; g = gg; sb = ss; sec = (b == 1);
        end
      end
    end
  endtask

  task automatic tick(input string req);
    bit ev; int evec; int eg; int es; bit esec;
    model(ev, evec, eg, es, esec);
    @(posedge clk);
    #1;
    n_chk++;
    if (win_valid !== ev || int'(win_vec) != evec || int'(win_grp) != eg ||
        int'(win_sub) != es || win_sec !== esec) begin
      n_bad++;
      $display("FAIL %s: got v=%0b vec=%0d grp=%0d sub=%0d sec=%0b, expected v=%0b vec=%0d grp=%0d sub=%0d sec=%0b",
               req, win_valid, win_vec, int'(win_grp), win_sub, win_sec,
               ev, evec, eg, es, esec);
    end
  endtask

  task automatic clear_all();
    s_en = '0; s_pend = '0; n_en = '0; n_pend = '0;
    s_prio = '0; n_prio = '0; ns_tgt_sec = '0; fixed_neg = '0;
    sec_bpoint = '0; ns_bpoint = '0;
  endtask

  task automatic set_s(input int i, input int p);
    s_en[i] = 1'b1; s_pend[i] = 1'b1; s_prio[i*PW +: PW] = PW'(p);
  endtask

  task automatic set_n(input int i, input int p);
    n_en[i] = 1'b1; n_pend[i] = 1'b1; n_prio[i*PW +: PW] = PW'(p);
  endtask

  initial begin
    #(5.0 * 20000);
    if (!done) begin
      n_bad++; n_chk++;
      $display("FAIL watchdog: got no finish, expected end of run");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end

  initial begin
    clear_all();
    rst = 1'b1;
    set_s(3, 5);
    tick("R10 reset idle");
    tick("R10 reset idle");
    #1 rst = 1'b0;
    clear_all();
    tick("R9 nothing live");

    // R1: pending without enable, and enable without pending, are ignored
    s_pend[4] = 1'b1; s_prio[4*PW +: PW] = 8'h00;
    n_en[5] = 1'b1; n_prio[5*PW +: PW] = 8'h00;
    tick("R1 not live ignored");
    set_s(9, 8'h40);
    tick("R1 only live copy");

    // R2: lowest group priority
    clear_all();
    set_s(2, 8'h80); set_n(7, 8'h20); set_s(12, 8'h60);
    tick("R2 lowest group");
    set_n(14, 8'h10);
    tick("R2 lowest group later vector");

    // R3: equal group, lower subpriority wins (bp = 4)
    clear_all();
    sec_bpoint = 4'd4; ns_bpoint = 4'd4;
    set_s(3, 8'h27); set_s(10, 8'h22);
    tick("R3 sub tiebreak");
    set_n(1, 8'h29);
    tick("R3 sub tiebreak lower vector loses");

    // R4: full tie, lowest vector number
    clear_all();
    set_n(11, 8'h30); set_n(6, 8'h30);
    tick("R4 lowest vector");

    // R5: same vector, both banks tied, secure copy wins
    clear_all();
    set_n(8, 8'h50); set_s(8, 8'h50);
    tick("R5 secure first");
    s_prio[8*PW +: PW] = 8'h51;
    tick("R5 strictly better ns copy");

    // R6: mask chosen from target state; clamp above PW
    clear_all();
    sec_bpoint = 4'd0; ns_bpoint = 4'd6;
    set_n(5, 8'h45); set_n(6, 8'h41);
    tick("R6 ns bp split");
    ns_tgt_sec[5] = 1'b1;
    tick("R6 route to secure mask");
    ns_tgt_sec[5] = 1'b0; ns_tgt_sec[6] = 1'b1;
    tick("R6 route other vector");
    clear_all();
    sec_bpoint = 4'd15; ns_bpoint = 4'd8;
    set_s(4, 8'hF0); set_n(2, 8'hA0); set_s(13, 8'h05);
    tick("R6 bp clamp all sub");

    // R7: fixed negative levels, no subpriority compare
    clear_all();
    fixed_neg[9] = 1'b1; fixed_neg[3] = 1'b1;
    set_s(9, 8'hF1); set_s(3, 8'h01); set_n(1, 8'h00);
    tick("R7 fixed equal level lower vector");
    s_prio[9*PW +: PW] = 8'h03;
    tick("R7 deeper fixed level");
    set_n(9, 8'hFF);
    tick("R7 fixed bank tie");

    // R8: vector 0 never reported
    clear_all();
    set_s(0, 0); set_n(0, 0); fixed_neg[0] = 1'b1;
    tick("R8 vector zero alone");
    set_n(15, 8'hFF);
    tick("R8 vector zero with other");

    // R10: output follows one cycle later, reset mid-run
    clear_all();
    set_s(7, 8'h10);
    tick("R10 registered update");
    s_en[7] = 1'b0;
    tick("R10 registered drop");
    set_s(7, 8'h10);
    rst = 1'b1;
    tick("R10 reset mid-run");
    rst = 1'b0;
    tick("R10 after reset");

    // Random mixes covering R2 R3 R4 R5 R6 R7
    for (int t = 0; t < 2000; t++) begin
      s_en = NV'($urandom); s_pend = NV'($urandom) & NV'($urandom);
      n_en = NV'($urandom); n_pend = NV'($urandom) & NV'($urandom);
      ns_tgt_sec = NV'($urandom);
      fixed_neg = NV'($urandom) & NV'($urandom) & NV'($urandom);
      for (int i = 0; i < NV; i++) begin
        s_prio[i*PW +: PW] = PW'($urandom % 4) << 6 | PW'($urandom % 4);
        n_prio[i*PW +: PW] = PW'($urandom % 4) << 6 | PW'($urandom % 4);
      end
      sec_bpoint = BW'($urandom % 10);
      ns_bpoint  = BW'($urandom % 10);
      tick("R2 R3 R4 R5 R6 R7 random");
    end

    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule